// File: doc/BRIEF.md
# Operand-Isolated Execute ALU

This block is the execute-stage arithmetic/logic unit of a 32-bit integer pipeline. It has two separate units: an adder-based unit for the add, subtract, reverse-subtract and compare operations, and a bitwise unit for the logical operations. The second operand first passes through a barrel shifter in the issue cycle. The unit-select bit comes straight from early decode. It gates which unit's operand registers capture new values, so the adder's two 32-bit inputs stay frozen on every cycle that carries a logical operation or no operation at all. The held operands take the place of the pipeline register the adder would need anyway, so isolation costs no extra cycle.

A small execute-slot state machine records what the slot holds. It has three states: `EX_IDLE` (no operation), `EX_ARITH` (adder result selected) and `EX_LOGIC` (bitwise result selected). On every clock it takes one of three transitions, and these do not depend on the present state. With no valid issue it goes to `EX_IDLE`. A valid issue with an opcode below 8 goes to `EX_ARITH`. A valid issue with an opcode of 8 or more goes to `EX_LOGIC`. The result, the four condition flags, the register write strobe and the flag-update strobe are all decoded from this state.

A counter output reports how many arithmetic issues actually changed the adder's operand registers. A bench can use it to show that the adder stays quiet through runs of logical operations.

Top module: `oiso_alu`

## Requirements
- R1: An issue presented with `in_valid` high at a rising edge appears on the outputs after that edge, with `out_valid` high. A cycle with `in_valid` low gives `out_valid` low after its edge.
- R2: Arithmetic opcodes give result and flags as follows, where B is the shifted second operand and Cin is `in_c`. 0: A+B. 1: A+B+Cin. 2: A−B. 3: A−B−(1−Cin). 4: B−A. 5: B−A−(1−Cin). 6: A−B, compare only. 7: A+B, compare only. C is the carry out of the sum, which for subtraction means no borrow. V is signed overflow.
- R3: Logical opcodes give the following results. 8: A&B. 9: A|B. 10: A^B. 11: A&~B. 12: B. 13: ~B. 14: A&B, test only. 15: A^B, test only.
- R4: The shifter kind encoding is 0 shift left, 1 logical shift right, 2 arithmetic shift right, 3 rotate right. The amount is 5 bits, and an amount of 0 passes B unchanged.
- R5: For logical opcodes, C is the last bit shifted out, or `in_c` when the amount is 0, and V equals `in_v`. For every opcode, N is result bit 31 and Z is set when the result is zero.
- R6: Opcodes 6, 7, 14 and 15 raise `out_flag_upd` without `out_wr_en`. All other valid opcodes raise both.
- R7: The adder operand registers, and therefore `out_adder_loads`, do not change on logical or idle cycles.
- R8: `out_adder_loads` increases by exactly one on each arithmetic issue whose A or shifted B differs from the values held, and is unchanged otherwise.
- R9: After reset, `out_valid`, `out_wr_en`, `out_flag_upd` and `out_adder_loads` are all zero, and the held operands are zero.
- R10: While `out_valid` is low, `out_wr_en` and `out_flag_upd` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Issue strobe |
| in_op | input | 4 | Opcode; bit 3 low selects the adder unit |
| in_opa | input | 32 | First operand |
| in_opb | input | 32 | Second operand, before shifting |
| in_shkind | input | 2 | Shift kind |
| in_shamt | input | 5 | Shift amount |
| in_c | input | 1 | Current carry flag |
| in_v | input | 1 | Current overflow flag |
| out_valid | output | 1 | Result valid |
| out_result | output | 32 | Selected unit result |
| out_wr_en | output | 1 | Register write strobe |
| out_flag_upd | output | 1 | Flag update strobe |
| out_n | output | 1 | Negative flag |
| out_z | output | 1 | Zero flag |
| out_c | output | 1 | Carry flag |
| out_v | output | 1 | Overflow flag |
| out_adder_loads | output | 16 | Count of adder-input changes |

## Verification
A wrong unit select or a broken state register shows at once: the result and flags one edge after the issue come from the wrong unit. An isolation enable that leaks shows up in `out_adder_loads`. It rises during a run of logical issues within a single cycle, and it is stale when the next arithmetic issue reuses the held operands. A shifter carry or flag mix-up shows in the C and V bits of the very next result.

// File: rtl/oiso_alu_pkg.sv
package oiso_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD    = 4'd0,
        OP_ADDC   = 4'd1,
        OP_SUB    = 4'd2,
        OP_SUBC   = 4'd3,
        OP_RSUB   = 4'd4,
        OP_RSUBC  = 4'd5,
        OP_CMPSUB = 4'd6,
        OP_CMPADD = 4'd7,
        OP_AND    = 4'd8,
        OP_OR     = 4'd9,
        OP_XOR    = 4'd10,
        OP_ANDN   = 4'd11,
        OP_PASS   = 4'd12,
        OP_NOT    = 4'd13,
        OP_TSTAND = 4'd14,
        OP_TSTXOR = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LSL = 2'd0,
        SH_LSR = 2'd1,
        SH_ASR = 2'd2,
        SH_ROR = 2'd3
    } shift_e;

    typedef enum logic [1:0] {
        EX_IDLE  = 2'd0,
        EX_ARITH = 2'd1,
        EX_LOGIC = 2'd2
    } ex_state_e;

    function automatic logic op_is_probe(input alu_op_e op);
        return (op == OP_CMPSUB) || (op == OP_CMPADD) ||
               (op == OP_TSTAND) || (op == OP_TSTXOR);
    endfunction

endpackage

// File: rtl/oiso_shifter.sv
module oiso_shifter
    import oiso_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]         din,
    input  shift_e               kind,
    input  logic [$clog2(W)-1:0] amt,
    input  logic                 cin,
    output logic [W-1:0]         dout,
    output logic                 cout
);
    localparam int SHW = $clog2(W);

    logic [SHW-1:0] amt_m1;
    logic [SHW-1:0] amt_neg;

    assign amt_m1  = amt - SHW'(1);
    assign amt_neg = SHW'(0) - amt;

    always_comb begin
        dout = din;
        cout = cin;
        if (amt != '0) begin
            unique case (kind)
                SH_LSL: begin
                    dout = din << amt;
                    cout = din[amt_neg];
                end
                SH_LSR: begin
                    dout = din >> amt;
                    cout = din[amt_m1];
                end
                SH_ASR: begin
                    dout = W'($signed(din) >>> amt);
                    cout = din[amt_m1];
                end
                SH_ROR: begin
                    dout = (din >> amt) | (din << amt_neg);
                    cout = din[amt_m1];
                end
            endcase
        end
    end

endmodule

// File: rtl/oiso_arith_unit.sv
module oiso_arith_unit
    import oiso_alu_pkg::*;
#(
    parameter int W     = 32,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  alu_op_e          op,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    input  logic             cin,
    output logic [W-1:0]     sum,
    output logic             c_out,
    output logic             v_out,
    output logic [CNT_W-1:0] loads
);
    logic [W-1:0]     a_q, b_q;
    alu_op_e          op_q;
    logic             cin_q;
    logic [CNT_W-1:0] cnt_q;
    logic [W-1:0]     x, y;
    logic             ci;
    logic             differs;

    assign differs = (a != a_q) || (b != b_q);

    // isolation registers: capture only on adder cycles
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q   <= '0;
            b_q   <= '0;
            op_q  <= OP_ADD;
            cin_q <= 1'b0;
        end else if (load) begin
            a_q   <= a;
            b_q   <= b;
            op_q  <= op;
            cin_q <= cin;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load && differs && (cnt_q != '1)) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    always_comb begin
        x  = a_q;
        y  = b_q;
        ci = 1'b0;
        unique case (op_q)
            OP_ADD, OP_CMPADD: begin
                ci = 1'b0;
            end
            OP_ADDC: begin
                ci = cin_q;
            end
            OP_SUB, OP_CMPSUB: begin
                y  = ~b_q;
                ci = 1'b1;
            end
            OP_SUBC: begin
                y  = ~b_q;
                ci = cin_q;
            end
            OP_RSUB: begin
                x  = b_q;
                y  = ~a_q;
                ci = 1'b1;
            end
            OP_RSUBC: begin
                x  = b_q;
                y  = ~a_q;
                ci = cin_q;
            end
            default: begin
                ci = 1'b0;
            end
        endcase
        {c_out, sum} = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
        v_out = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
    end

    assign loads = cnt_q;

    AST_ISO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(a_q) && $stable(b_q))) else $error("iso hold"); // R7
    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(cnt_q)) else $error("count idle"); // R7
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CNT_W'(1))))
        else $error("count step"); // R8

endmodule

// File: rtl/oiso_logic_unit.sv
module oiso_logic_unit
    import oiso_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sh_c,
    input  logic         v_in,
    output logic [W-1:0] result,
    output logic         c_out,
    output logic         v_out
);
    logic [W-1:0] a_q, b_q;
    alu_op_e      op_q;
    logic         c_q, v_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q  <= '0;
            b_q  <= '0;
            op_q <= OP_AND;
            c_q  <= 1'b0;
            v_q  <= 1'b0;
        end else if (load) begin
            a_q  <= a;
            b_q  <= b;
            op_q <= op;
            c_q  <= sh_c;
            v_q  <= v_in;
        end
    end

    always_comb begin
        unique case (op_q)
            OP_AND, OP_TSTAND: result = a_q & b_q;
            OP_OR:             result = a_q | b_q;
            OP_XOR, OP_TSTXOR: result = a_q ^ b_q;
            OP_ANDN:           result = a_q & ~b_q;
            OP_PASS:           result = b_q;
            OP_NOT:            result = ~b_q;
            default:           result = '0;
        endcase
    end

    assign c_out = c_q;
    assign v_out = v_q;

endmodule

// File: rtl/oiso_alu.sv
module oiso_alu
    import oiso_alu_pkg::*;
#(
    parameter int W     = 32,
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [3:0]           in_op,
    input  logic [W-1:0]         in_opa,
    input  logic [W-1:0]         in_opb,
    input  logic [1:0]           in_shkind,
    input  logic [$clog2(W)-1:0] in_shamt,
    input  logic                 in_c,
    input  logic                 in_v,
    output logic                 out_valid,
    output logic [W-1:0]         out_result,
    output logic                 out_wr_en,
    output logic                 out_flag_upd,
    output logic                 out_n,
    output logic                 out_z,
    output logic                 out_c,
    output logic                 out_v,
    output logic [CNT_W-1:0]     out_adder_loads
);
    alu_op_e   op_d;
    logic      arith_sel;
    logic      arith_load, logic_load;
    logic      wr_q;
    ex_state_e state_q, state_d;

    logic [W-1:0] b_sh;
    logic         b_sh_c;
    logic [W-1:0] ar_sum, lu_res;
    logic         ar_c, ar_v, lu_c, lu_v;

    // early decode: unit select from the top opcode bit
    assign op_d       = alu_op_e'(in_op);
    assign arith_sel  = !in_op[3];
    assign arith_load = in_valid && arith_sel;
    assign logic_load = in_valid && !arith_sel;

    oiso_shifter #(.W(W)) shf_i (
        .din  (in_opb),
        .kind (shift_e'(in_shkind)),
        .amt  (in_shamt),
        .cin  (in_c),
        .dout (b_sh),
        .cout (b_sh_c)
    );

    oiso_arith_unit #(.W(W), .CNT_W(CNT_W)) aru_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (arith_load),
        .op    (op_d),
        .a     (in_opa),
        .b     (b_sh),
        .cin   (in_c),
        .sum   (ar_sum),
        .c_out (ar_c),
        .v_out (ar_v),
        .loads (out_adder_loads)
    );

    oiso_logic_unit #(.W(W)) lgu_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (logic_load),
        .op     (op_d),
        .a      (in_opa),
        .b      (b_sh),
        .sh_c   (b_sh_c),
        .v_in   (in_v),
        .result (lu_res),
        .c_out  (lu_c),
        .v_out  (lu_v)
    );

    always_comb begin
        if (!in_valid)      state_d = EX_IDLE;
        else if (arith_sel) state_d = EX_ARITH;
        else                state_d = EX_LOGIC;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= EX_IDLE;
            wr_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            wr_q    <= in_valid && !op_is_probe(op_d);
        end
    end

    always_comb begin
        out_valid    = 1'b0;
        out_result   = lu_res;
        out_wr_en    = 1'b0;
        out_flag_upd = 1'b0;
        out_c        = lu_c;
        out_v        = lu_v;
        unique case (state_q)
            EX_IDLE: begin
                out_valid = 1'b0;
            end
            EX_ARITH: begin
                out_valid    = 1'b1;
                out_result   = ar_sum;
                out_wr_en    = wr_q;
                out_flag_upd = 1'b1;
                out_c        = ar_c;
                out_v        = ar_v;
            end
            EX_LOGIC: begin
                out_valid    = 1'b1;
                out_result   = lu_res;
                out_wr_en    = wr_q;
                out_flag_upd = 1'b1;
            end
            default: begin
                out_valid = 1'b0;
            end
        endcase
        out_n = out_result[W-1];
        out_z = (out_result == '0);
    end

    AST_ISSUE_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid) else $error("latency"); // R1
    AST_IDLE_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid) else $error("idle"); // R1
    AST_STROBE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_wr_en && !out_flag_upd)) else $error("strobes"); // R10
    AST_PROBE_NOWR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_is_probe(op_d)) |=> (out_flag_upd && !out_wr_en)) else $error("probe"); // R6
    AST_LOGIC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        logic_load |=> $stable(out_adder_loads)) else $error("quiet"); // R7

endmodule

// File: tb/oiso_alu_tb_top.sv
module oiso_alu_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_op = '0;
    logic [31:0] in_opa = '0, in_opb = '0;
    logic [1:0]  in_shkind = '0;
    logic [4:0]  in_shamt = '0;
    logic        in_c = 1'b0, in_v = 1'b0;
    logic        out_valid, out_wr_en, out_flag_upd, out_n, out_z, out_c, out_v;
    logic [31:0] out_result;
    logic [15:0] out_adder_loads;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    logic [31:0] m_pa = '0, m_pb = '0;
    int m_loads = 0;

    always #4 clk = ~clk;

    oiso_alu dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_opa(in_opa), .in_opb(in_opb), .in_shkind(in_shkind),
        .in_shamt(in_shamt), .in_c(in_c), .in_v(in_v),
        .out_valid(out_valid), .out_result(out_result), .out_wr_en(out_wr_en),
        .out_flag_upd(out_flag_upd), .out_n(out_n), .out_z(out_z),
        .out_c(out_c), .out_v(out_v), .out_adder_loads(out_adder_loads)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [32:0] ref_shift(input logic [31:0] b, input logic [1:0] k,
                                              input logic [4:0] amt, input logic c);
        logic [63:0] t;
        logic [31:0] r;
        if (amt == 0) return {c, b};
        case (k)
            2'd0: begin t = {32'b0, b} << amt; return {t[32], t[31:0]}; end
            2'd1: begin t = {b, 32'b0} >> amt; return {t[31], t[63:32]}; end
            2'd2: begin t = 64'($signed({b, 32'b0}) >>> amt); return {t[31], t[63:32]}; end
            default: begin t = {b, b} >> amt; r = t[31:0]; return {r[31], r}; end
        endcase
    endfunction

    task automatic issue(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [1:0] k, input logic [4:0] amt,
                         input logic c, input logic v);
        logic [32:0] sh;
        logic [31:0] bs, er;
        logic ec, ev, ewr;
        logic [33:0] u;
        longint sr;
        string rq;
        sh = ref_shift(b, k, amt, c);
        bs = sh[31:0];
        ewr = !(op == 6 || op == 7 || op == 14 || op == 15);
        ev = v;
        ec = sh[32];
        er = '0;
        if (op < 8) begin
            case (op)
                0, 1, 7: begin
                    u  = {2'b0, a} + {2'b0, bs} + ((op == 1) ? {33'b0, c} : 34'd0);
                    sr = longint'($signed(a)) + longint'($signed(bs)) + ((op == 1) ? longint'(c) : 0);
                end
                2, 3, 6: begin
                    u  = {2'b0, a} - {2'b0, bs} - ((op == 3) ? {33'b0, !c} : 34'd0);
                    sr = longint'($signed(a)) - longint'($signed(bs)) - ((op == 3) ? longint'(!c) : 0);
                end
                default: begin
                    u  = {2'b0, bs} - {2'b0, a} - ((op == 5) ? {33'b0, !c} : 34'd0);
                    sr = longint'($signed(bs)) - longint'($signed(a)) - ((op == 5) ? longint'(!c) : 0);
                end
            endcase
            er = u[31:0];
            ec = (op == 0 || op == 1 || op == 7) ? u[32] : !u[33];
            ev = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
            if (a != m_pa || bs != m_pb) m_loads++;
            m_pa = a;
            m_pb = bs;
        end else begin
            case (op)
                8, 14:   er = a & bs;
                9:       er = a | bs;
                10, 15:  er = a ^ bs;
                11:      er = a & ~bs;
                12:      er = bs;
                default: er = ~bs;
            endcase
        end
        rq = (op < 8) ? "R2" : "R3";
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_opa = a; in_opb = b;
        in_shkind = k; in_shamt = amt; in_c = c; in_v = v;
        @(posedge clk);
        #2;
        chk("R1", "valid", 32'(out_valid), 32'd1);
        chk(rq, "result", out_result, er);
        chk((op < 8) ? "R2" : "R5", "nzcv", {28'b0, out_n, out_z, out_c, out_v},
            {28'b0, er[31], er == 0, ec, ev});
        chk("R6", "wr/upd", {30'b0, out_wr_en, out_flag_upd}, {30'b0, ewr, 1'b1});
        chk((op < 8) ? "R8" : "R7", "loads", 32'(out_adder_loads), 32'(m_loads));
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        in_op = 4'($urandom);
        in_opa = $urandom;
        @(posedge clk);
        #2;
        chk("R1", "idle valid", 32'(out_valid), 32'd0);
        chk("R10", "idle strobes", {30'b0, out_wr_en, out_flag_upd}, 32'd0);
        chk("R7", "idle loads", 32'(out_adder_loads), 32'(m_loads));
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1CE5EED));
        repeat (3) @(posedge clk);
        #2;
        chk("R9", "reset state", {13'b0, out_valid, out_wr_en, out_flag_upd, out_adder_loads},
            32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        // held operands are zero: an arithmetic issue of zeros is not a change (R9, R8)
        issue(4'd0, 32'd0, 32'd0, 2'd0, 5'd0, 1'b0, 1'b0);
        // R2 directed corners
        issue(4'd0, 32'h7FFF_FFFF, 32'd1, 2'd0, 5'd0, 1'b0, 1'b0);
        issue(4'd2, 32'd5, 32'd5, 2'd0, 5'd0, 1'b0, 1'b0);
        issue(4'd3, 32'd5, 32'd5, 2'd0, 5'd0, 1'b0, 1'b0);
        issue(4'd1, 32'hFFFF_FFFF, 32'd0, 2'd0, 5'd0, 1'b1, 1'b0);
        issue(4'd4, 32'd3, 32'd1, 2'd0, 5'd0, 1'b0, 1'b0);
        issue(4'd5, 32'd1, 32'd3, 2'd0, 5'd0, 1'b0, 1'b0);
        issue(4'd6, 32'h8000_0000, 32'd1, 2'd0, 5'd0, 1'b0, 1'b0);
        issue(4'd7, 32'h8000_0000, 32'h8000_0000, 2'd0, 5'd0, 1'b0, 1'b0);
        // R8: same operands again, no count
        issue(4'd2, 32'h8000_0000, 32'h8000_0000, 2'd0, 5'd0, 1'b0, 1'b0);
        // R4 / R5 shifter corners on logic ops
        issue(4'd12, 32'd0, 32'h8000_0001, 2'd0, 5'd1, 1'b0, 1'b1);
        issue(4'd12, 32'd0, 32'h8000_0001, 2'd1, 5'd1, 1'b0, 1'b0);
        issue(4'd12, 32'd0, 32'h8000_0002, 2'd2, 5'd31, 1'b0, 1'b0);
        issue(4'd12, 32'd0, 32'h0000_0001, 2'd3, 5'd1, 1'b0, 1'b0);
        issue(4'd13, 32'd0, 32'h1234_5678, 2'd3, 5'd0, 1'b1, 1'b1);
        issue(4'd14, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 2'd0, 5'd0, 1'b0, 1'b0);
        issue(4'd15, 32'hAAAA_5555, 32'hAAAA_5555, 2'd0, 5'd0, 1'b1, 1'b0);
        // R7: long run of logical ops keeps the adder count frozen
        for (int i = 0; i < 40; i++)
            issue(4'(8 + ($urandom % 8)), $urandom, $urandom, 2'($urandom), 5'($urandom),
                  1'($urandom), 1'($urandom));
        idle();
        // mixed random traffic
        for (int i = 0; i < 1500; i++) begin
            if (($urandom % 8) == 0) idle();
            else issue(4'($urandom), $urandom, $urandom, 2'($urandom), 5'($urandom),
                       1'($urandom), 1'($urandom));
        end
        idle();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule